// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a register-mapped watchdog. A 32-bit counter climbs from a programmable start value, one step per tick or one step per 2^k ticks when the prescaler is on. When the counter steps past all-ones it reloads itself from the load register and raises a reset output for one clock. Software keeps the system alive by changing the trigger register, which copies the load value back into the counter.

Arming and disarming require an ordered pair of key words written to the arm register. A single stray write cannot start or stop the timer. Every writable register is posted: a write first shows up as a busy bit in the pending register. It takes effect only after a fixed number of tick enables, so software polls the pending register before it relies on a write.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the timer is disarmed, and the control (0x24), counter (0x28), load (0x2C), trigger (0x30) and pending (0x34) registers all read zero. `wdt_rst_o` is low.
- R2: A read of offset 0x00 returns the revision, with the major number in bits 7:4 and the minor number in bits 3:0. All other bits are zero.
- R3: A write to control, counter, load, trigger or arm (0x48) sets pending bit 0, 1, 2, 3 or 4 respectively. The bit is set from the cycle after the write. The write takes effect on the clock edge of the POST_TICKS-th tick enable (default 2), and the bit clears at that same edge.
- R4: A committed arm write of 0x0000BBBB followed by a committed arm write of 0x00004444 arms the timer. While the timer is disarmed the counter holds its value and `wdt_rst_o` stays low.
- R5: A committed arm write of 0x0000AAAA followed by a committed arm write of 0x00005555 disarms the timer.
- R6: An arm write that is not a first key leaves the key state unchanged. Any arm write other than the expected second key aborts the sequence. In both cases the timer does not change between armed and disarmed.
- R7: While armed with the prescaler off (control bit 5 = 0), the counter increases by one on every tick enable.
- R8: Control bit 5 turns the prescaler on, and control bits 4:2 hold an exponent k. With the prescaler on, the counter advances once per 2^k tick enables. A read of control returns those bits.
- R9: A step taken while the counter holds 0xFFFFFFFF loads the counter with the load register and drives `wdt_rst_o` high for exactly one cycle. A load value of 2^32 - N*32768 therefore gives N*32768 ticks between reset pulses.
- R10: A committed trigger write whose value differs from the trigger register copies the load register into the counter. A committed trigger write of the same value leaves the counter counting undisturbed.
- R11: A committed counter write sets the counter to the written value, armed or not.
- R12: When a counter or trigger reload commits on the same edge as a count step, the reload wins. No reset pulse comes from that step, even if the counter was at all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| tick_en | input | 1 | Timebase tick enable, one per timebase period |
| wdt_rst_o | output | 1 | Watchdog reset pulse, one cycle high |

## Verification
Two counter updates can land on the same clock edge: the count step that would overflow past all-ones, and a posted trigger reload completing. The bench provokes this by writing the counter to 0xFFFFFFFD right before a differing trigger write. With ticks every cycle, the counter then reaches all-ones exactly as the trigger commits. The case is judged by reading the counter at the commit and expecting the load value, while `wdt_rst_o` must stay low through that edge and the cycles after it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // Register byte offsets; software decodes these.
   localparam logic [7:0] OFS_REV  = 8'h00;
   localparam logic [7:0] OFS_CTRL = 8'h24;
   localparam logic [7:0] OFS_CNT  = 8'h28;
   localparam logic [7:0] OFS_LOAD = 8'h2C;
   localparam logic [7:0] OFS_TRIG = 8'h30;
   localparam logic [7:0] OFS_PEND = 8'h34;
   localparam logic [7:0] OFS_ARM  = 8'h48;

   // Posted slots, index equals pending bit position.
   localparam int SLOT_CTRL = 0;
   localparam int SLOT_CNT  = 1;
   localparam int SLOT_LOAD = 2;
   localparam int SLOT_TRIG = 3;
   localparam int SLOT_ARM  = 4;
   localparam int NUM_SLOTS = 5;

   localparam logic [15:0] KEY_ARM_A = 16'hBBBB;
   localparam logic [15:0] KEY_ARM_B = 16'h4444;
   localparam logic [15:0] KEY_DIS_A = 16'hAAAA;
   localparam logic [15:0] KEY_DIS_B = 16'h5555;

   typedef enum logic [1:0] {
      KS_IDLE   = 2'd0,
      KS_ARMING = 2'd1,
      KS_DISARM = 2'd2
   } key_state_e;

   function automatic logic [7:0] slot_offset(input int slot);
      case (slot)
         SLOT_CTRL: slot_offset = OFS_CTRL;
         SLOT_CNT:  slot_offset = OFS_CNT;
         SLOT_LOAD: slot_offset = OFS_LOAD;
         SLOT_TRIG: slot_offset = OFS_TRIG;
         default:   slot_offset = OFS_ARM;
      endcase
   endfunction
endpackage

// File: rtl/wdt_post.sv
module wdt_post #(
   parameter int DATA_W     = 32,
   parameter int POST_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              tick_i,
   output logic              busy_o,
   output logic              commit_o,
   output logic [DATA_W-1:0] data_o
);
   localparam int CW = $clog2(POST_TICKS + 1);

   logic [CW-1:0]     cnt_q;
   logic              busy_q;
   logic [DATA_W-1:0] hold_q;

   // A fresh write restarts the posting window instead of committing.
   assign commit_o = busy_q && tick_i && !wr_i && (cnt_q == CW'(POST_TICKS - 1));
   assign busy_o   = busy_q;
   assign data_o   = hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         hold_q <= '0;
      end else if (wr_i) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         hold_q <= wdata_i;
      end else if (commit_o) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q && tick_i) begin
         cnt_q  <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/wdt_key.sv
module wdt_key
   import wdt_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              armed_o
);
   key_state_e state_q;
   logic       armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= KS_IDLE;
         armed_q <= 1'b0;
      end else if (commit_i) begin
         case (state_q)
            KS_IDLE: begin
               if (data_i == DATA_W'(KEY_ARM_A))      state_q <= KS_ARMING;
               else if (data_i == DATA_W'(KEY_DIS_A)) state_q <= KS_DISARM;
            end
            KS_ARMING: begin
               if (data_i == DATA_W'(KEY_ARM_B)) armed_q <= 1'b1;
               state_q <= KS_IDLE;
            end
            default: begin
               if (data_i == DATA_W'(KEY_DIS_B)) armed_q <= 1'b0;
               state_q <= KS_IDLE;
            end
         endcase
      end
   end

   assign armed_o = armed_q;
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int DATA_W = 32,
   parameter int PRE_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              tick_i,
   input  logic              pre_en_i,
   input  logic [PRE_W-1:0]  pre_exp_i,
   input  logic              force_i,
   input  logic [DATA_W-1:0] force_val_i,
   input  logic [DATA_W-1:0] reload_i,
   output logic [DATA_W-1:0] count_o,
   output logic              ovf_o
);
   localparam int DIV_W = 1 << PRE_W;

   logic [DIV_W-1:0]  div_q;
   logic [DIV_W-1:0]  div_mask;
   logic              div_hit;
   logic              step;
   logic [DATA_W-1:0] cnt_q;
   logic              ovf_q;

   assign div_mask = (DIV_W'(1) << pre_exp_i) - DIV_W'(1);
   assign div_hit  = (div_q >= div_mask);
   assign step     = run_i && tick_i && (!pre_en_i || div_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (!run_i || !pre_en_i) begin
         div_q <= '0;
      end else if (tick_i) begin
         div_q <= div_hit ? '0 : div_q + DIV_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= step && !force_i && (cnt_q == '1);
         if (force_i)
            cnt_q <= force_val_i;
         else if (step)
            cnt_q <= (cnt_q == '1) ? reload_i : cnt_q + DATA_W'(1);
      end
   end

   assign count_o = cnt_q;
   assign ovf_o   = ovf_q;
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
   import wdt_pkg::*;
#(
   parameter int         DATA_W     = 32,
   parameter int         ADDR_W     = 8,
   parameter int         PRE_W      = 3,
   parameter int         POST_TICKS = 2,
   parameter logic [3:0] REV_MAJOR  = 4'h1,
   parameter logic [3:0] REV_MINOR  = 4'h3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_en,
   output logic              wdt_rst_o
);
   localparam int CTRL_EXP_LSB = 2;
   localparam int CTRL_EN_BIT  = CTRL_EXP_LSB + PRE_W;

   if (DATA_W < 16)        $error("DATA_W must hold a 16-bit key");
   if (ADDR_W < 8)         $error("ADDR_W must reach offset 0x48");
   if (PRE_W < 1 || PRE_W > 4) $error("PRE_W out of range");
   if (POST_TICKS < 1)     $error("POST_TICKS must be at least 1");
   if (CTRL_EN_BIT >= DATA_W) $error("control field does not fit");

   logic [NUM_SLOTS-1:0] wr_sel;
   logic [NUM_SLOTS-1:0] busy;
   logic [NUM_SLOTS-1:0] commit;
   logic [DATA_W-1:0]    slot_data [NUM_SLOTS];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign wr_sel[s] = bus_we && (bus_addr == ADDR_W'(slot_offset(s)));
      wdt_post #(.DATA_W(DATA_W), .POST_TICKS(POST_TICKS)) i_post (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_i     (wr_sel[s]),
         .wdata_i  (bus_wdata),
         .tick_i   (tick_en),
         .busy_o   (busy[s]),
         .commit_o (commit[s]),
         .data_o   (slot_data[s])
      );
   end

   logic              pre_en_q;
   logic [PRE_W-1:0]  pre_exp_q;
   logic [DATA_W-1:0] load_q;
   logic [DATA_W-1:0] trig_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_en_q  <= 1'b0;
         pre_exp_q <= '0;
         load_q    <= '0;
         trig_q    <= '0;
      end else begin
         if (commit[SLOT_CTRL]) begin
            pre_en_q  <= slot_data[SLOT_CTRL][CTRL_EN_BIT];
            pre_exp_q <= slot_data[SLOT_CTRL][CTRL_EXP_LSB +: PRE_W];
         end
         if (commit[SLOT_LOAD]) load_q <= slot_data[SLOT_LOAD];
         if (commit[SLOT_TRIG]) trig_q <= slot_data[SLOT_TRIG];
      end
   end

   logic armed;

   wdt_key #(.DATA_W(DATA_W)) i_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (commit[SLOT_ARM]),
      .data_i   (slot_data[SLOT_ARM]),
      .armed_o  (armed)
   );

   logic              trig_reload;
   logic              cnt_force;
   logic [DATA_W-1:0] cnt_force_val;
   logic [DATA_W-1:0] count;

   assign trig_reload   = commit[SLOT_TRIG] && (slot_data[SLOT_TRIG] != trig_q);
   assign cnt_force     = trig_reload || commit[SLOT_CNT];
   assign cnt_force_val = trig_reload ? load_q : slot_data[SLOT_CNT];

   wdt_count #(.DATA_W(DATA_W), .PRE_W(PRE_W)) i_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (armed),
      .tick_i      (tick_en),
      .pre_en_i    (pre_en_q),
      .pre_exp_i   (pre_exp_q),
      .force_i     (cnt_force),
      .force_val_i (cnt_force_val),
      .reload_i    (load_q),
      .count_o     (count),
      .ovf_o       (wdt_rst_o)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_REV):  bus_rdata[7:0] = {REV_MAJOR, REV_MINOR};
         ADDR_W'(OFS_CTRL): begin
            bus_rdata[CTRL_EN_BIT]             = pre_en_q;
            bus_rdata[CTRL_EXP_LSB +: PRE_W]   = pre_exp_q;
         end
         ADDR_W'(OFS_CNT):  bus_rdata = count;
         ADDR_W'(OFS_LOAD): bus_rdata = load_q;
         ADDR_W'(OFS_TRIG): bus_rdata = trig_q;
         ADDR_W'(OFS_PEND): bus_rdata[NUM_SLOTS-1:0] = busy;
         default:           bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
   import wdt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic              tick_en,
   input logic              wdt_rst_o,
   input logic [4:0]        busy,
   input logic              armed,
   input logic              pre_en_q,
   input logic              cnt_force,
   input logic [DATA_W-1:0] count,
   input logic [DATA_W-1:0] load_q
);
   // R9: the reset output never stays high two cycles in a row
   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_o |=> !wdt_rst_o);

   // R9: a reset pulse comes with the counter reloaded from the load value
   assert_ovf_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_o |-> (count == $past(load_q)));

   // R4: disarmed and not forced, the counter holds
   assert_disarmed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !cnt_force) |=> $stable(count));

   // R4: no reset pulse follows a disarmed cycle
   assert_disarmed_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !wdt_rst_o);

   // R7: armed, prescaler off, a tick adds one
   assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && tick_en && !pre_en_q && !cnt_force && (count != '1))
      |=> (count == $past(count) + DATA_W'(1)));

   // R3: a load write shows as pending in the next cycle
   assert_load_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == ADDR_W'(OFS_LOAD))) |=> busy[SLOT_LOAD]);

   // R3: an arm write shows as pending in the next cycle
   assert_arm_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == ADDR_W'(OFS_ARM))) |=> busy[SLOT_ARM]);
endmodule

bind wdt_keyed wdt_keyed_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_wdt_keyed_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .tick_en   (tick_en),
   .wdt_rst_o (wdt_rst_o),
   .busy      (busy),
   .armed     (armed),
   .pre_en_q  (pre_en_q),
   .cnt_force (cnt_force),
   .count     (count),
   .load_q    (load_q)
);

// File: tb/test_wdt_keyed.sv
module test_wdt_keyed;
   localparam logic [7:0] A_REV = 8'h00, A_CTRL = 8'h24, A_CNT = 8'h28, A_LOAD = 8'h2C,
                          A_TRIG = 8'h30, A_PEND = 8'h34, A_ARM = 8'h48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_en = 1'b1;
   logic        wdt_rst_o;

   int checks = 0;
   int fails = 0;
   logic [31:0] last_pend;

   always #5 clk = ~clk;

   wdt_keyed i_wdt_keyed (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
      .wdt_rst_o(wdt_rst_o)
   );

   function automatic logic [31:0] load_for(input int secs);
      return 32'(64'h1_0000_0000 - 64'(secs) * 64'd32768);
   endfunction

   function automatic logic [31:0] after_trig(input logic [31:0] cnt, load, old_t, new_t,
                                              input int cycles);
      return (new_t != old_t) ? load : cnt + 32'(cycles);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called at a negedge with bus_we low.
   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // Called at a negedge N0; returns at N3, just after the commit edge.
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
      bus_addr = A_PEND;
      #1;
      last_pend = bus_rdata;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v, c0, c1, ld, t_model, cnt_model, nt;
      int n;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CNT, v);  chk("R1 counter", v, 32'h0);
      rd(A_LOAD, v); chk("R1 load", v, 32'h0);
      rd(A_CTRL, v); chk("R1 control", v, 32'h0);
      rd(A_TRIG, v); chk("R1 trigger", v, 32'h0);
      rd(A_PEND, v); chk("R1 pending", v, 32'h0);
      chk("R1 reset out", 32'(wdt_rst_o), 32'h0);

      // R2 revision
      rd(A_REV, v); chk("R2 revision", v, 32'h13);

      // R3 posting, R11 direct counter write
      wr(A_LOAD, 32'h100);
      chk("R3 load pending", last_pend, 32'h4);
      rd(A_PEND, v); chk("R3 pending cleared", v, 32'h0);
      rd(A_LOAD, v); chk("R3 load committed", v, 32'h100);
      wr(A_CNT, 32'h55);
      chk("R3 counter pending", last_pend, 32'h2);
      rd(A_CNT, v); chk("R11 counter write", v, 32'h55);

      // R4 disarmed hold
      repeat (10) @(negedge clk);
      rd(A_CNT, v); chk("R4 disarmed hold", v, 32'h55);

      // R6 wrong first word, aborted sequence
      wr(A_ARM, 32'h1234);
      chk("R3 arm pending", last_pend, 32'h10);
      wr(A_ARM, 32'h4444);
      repeat (5) @(negedge clk);
      rd(A_CNT, v); chk("R6 stray second key", v, 32'h55);
      wr(A_ARM, 32'hBBBB); wr(A_ARM, 32'h1234); wr(A_ARM, 32'h4444);
      repeat (5) @(negedge clk);
      rd(A_CNT, v); chk("R6 aborted arm", v, 32'h55);

      // R4 arm, R7 stepping
      wr(A_ARM, 32'hBBBB); wr(A_ARM, 32'h4444);
      rd(A_CNT, c0); chk("R4 armed at commit", c0, 32'h55);
      repeat (5) @(negedge clk);
      rd(A_CNT, c1); chk("R7 one per tick", c1, c0 + 32'd5);

      // R8 prescaler with exponent 2
      wr(A_CTRL, 32'h28);
      rd(A_CTRL, v); chk("R8 control readback", v, 32'h28);
      rd(A_CNT, c0);
      repeat (40) @(negedge clk);
      rd(A_CNT, c1); chk("R8 divide by 4", c1, c0 + 32'd10);
      wr(A_CTRL, 32'h0);
      rd(A_CNT, c0);
      repeat (5) @(negedge clk);
      rd(A_CNT, c1); chk("R8 prescaler off", c1, c0 + 32'd5);

      // R10 trigger reload and same-value trigger
      wr(A_LOAD, 32'h1000);
      wr(A_TRIG, 32'h1);
      rd(A_CNT, v); chk("R10 differing trigger", v, 32'h1000);
      rd(A_CNT, c0);
      wr(A_TRIG, 32'h1);
      rd(A_CNT, v); chk("R10 same trigger", v, after_trig(c0, 32'h1000, 32'h1, 32'h1, 3));

      // R9 overflow
      wr(A_CNT, 32'hFFFF_FFF0);
      rd(A_CNT, v); chk("R11 counter write armed", v, 32'hFFFF_FFF0);
      n = 0;
      while (n < 64) begin
         @(negedge clk);
         n++;
         if (wdt_rst_o) break;
      end
      chk("R9 steps to pulse", 32'(n), 32'd16);
      rd(A_CNT, v); chk("R9 reload on overflow", v, 32'h1000);
      @(negedge clk);
      chk("R9 pulse one cycle", 32'(wdt_rst_o), 32'h0);
      rd(A_CNT, v); chk("R9 counting after reload", v, 32'h1001);

      // R9 one-second period
      ld = load_for(1);
      wr(A_LOAD, ld);
      wr(A_CNT, 32'hFFFF_FF80);
      n = 0;
      while (n < 400 && !wdt_rst_o) begin @(negedge clk); n++; end
      chk("R9 forced early pulse", 32'(wdt_rst_o), 32'h1);
      n = 0;
      do begin @(negedge clk); n++; end while (n < 40000 && !wdt_rst_o);
      chk("R9 one second period", 32'(n), 32'd32768);

      // R12 reload and overflow step on the same edge
      wr(A_CNT, 32'hFFFF_FFFD);
      wr(A_TRIG, 32'h2);
      rd(A_CNT, v); chk("R12 reload wins", v, ld);
      n = 0;
      for (int i = 0; i < 6; i++) begin
         if (wdt_rst_o) n++;
         @(negedge clk);
      end
      chk("R12 no reset pulse", 32'(n), 32'd0);

      // R5 disarm, with a broken sequence first
      wr(A_ARM, 32'hAAAA); wr(A_ARM, 32'h1234); wr(A_ARM, 32'h5555);
      rd(A_CNT, c0);
      repeat (4) @(negedge clk);
      rd(A_CNT, c1); chk("R6 broken disarm", c1, c0 + 32'd4);
      wr(A_ARM, 32'hAAAA); wr(A_ARM, 32'h5555);
      rd(A_CNT, c0);
      repeat (10) @(negedge clk);
      rd(A_CNT, c1); chk("R5 disarmed", c1, c0);

      // Random load and trigger traffic while disarmed (R10)
      t_model = 32'h2;
      rd(A_CNT, cnt_model);
      for (int k = 0; k < 16; k++) begin
         ld = $urandom;
         wr(A_LOAD, ld);
         nt = ($urandom % 2 == 0) ? t_model : t_model + 32'd1 + ($urandom & 32'hFF);
         wr(A_TRIG, nt);
         cnt_model = after_trig(cnt_model, ld, t_model, nt, 0);
         t_model = nt;
         rd(A_CNT, v); chk("R10 random trigger", v, cnt_model);
      end
      rd(A_TRIG, v); chk("R10 trigger readback", v, t_model);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule